// File: doc/BRIEF.md
# Halfword Host Port Target

This block is the target end of a 16-bit multiplexed host port. An external host reaches a word-addressed store of 32-bit entries held inside the block. It does so through three registers: a control register, an address register and a data window. A 2-bit select picks the register and the access style. Each 32-bit word crosses the port as a pair of halfword transfers. A halfword select line tells the block whether the current transfer is the first or the second of the pair. A control bit decides whether the first halfword carries the upper or the lower 16 bits.

The host qualifies every transfer with a chip select and two data strobes. The block merges these into one internal strobe, and the transfer takes effect when that strobe is released. The data window comes in two styles. In one, the address register moves on by one word after each full word. In the other, the address stays where it is. After a word has been written into the store, the ready output stays in its not-ready state for a fixed number of clocks, to model the store's access time. A local-side pulse raises a host interrupt flag. The host clears that flag through the control register.

The host-side pins are treated as synchronous to the block clock. The address strobe pin has no function in this mode and is ignored.

Top module: `hport16_slave`

## Requirements
- R1: The block drives `hp_data` only while a read strobe is qualified: `hp_cs_n` low, exactly one of `hp_ds1_n`/`hp_ds2_n` low, and `hp_rnw` high. At all other times the block leaves the bus undriven.
- R2: The strobe is qualified only when `hp_cs_n` is low and exactly one data strobe is low. A transfer commits on the clock where a qualified strobe ends. With both data strobes low, or with chip select high, nothing commits.
- R3: Select 00 reaches the control register. Bit 0 is the high-first flag and bit 1 is the interrupt flag, and the register reads back as {14'b0, interrupt, high-first} on either halfword. A host write sets bit 0 from data bit 0, clears the interrupt flag when data bit 1 is 1, and leaves the flag alone when data bit 1 is 0. All fields reset to 0.
- R4: Select 01 reaches the 32-bit address register, one halfword per transfer. A transfer with `hp_half`=0 is the first halfword. When high-first is 0, the first halfword carries bits 15:0; when high-first is 1, it carries bits 31:16. The second halfword carries the other half. The register is a byte address, and the store index is (address/4) modulo DEPTH.
- R5: Select 10 is the data window with post-increment. When the second halfword (`hp_half`=1) of a read or a write commits, the address register grows by 4.
- R6: Select 11 is the data window at a fixed address. Data transfers in this mode leave the address register unchanged.
- R7: A data write holds its first halfword and writes the full 32-bit word into the store when the second halfword commits. A data read of the first halfword returns its half of the stored word and latches the whole word. The second halfword returns the other half of that latched word. The halves are placed by the same rule as in R4.
- R8: `hp_rnw` high makes a transfer a read and low makes it a write.
- R9: `hp_rdy_n` is 0 out of reset. After a data word write commits, it reads 1 for exactly LAT clocks. A transfer that ends while `hp_rdy_n` is 1 has no effect.
- R10: A one-clock pulse on `loc_int_set` sets the interrupt flag, and `hp_int` follows the flag. If a local set and a host clear arrive on the same clock, the set wins.
- R11: `hp_as_n` has no effect on any transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| loc_int_set | input | 1 | Local-side pulse that raises the host interrupt flag |
| hp_sel | input | 2 | Register and access-style select |
| hp_half | input | 1 | Halfword select: 0 first, 1 second |
| hp_rnw | input | 1 | 1 read, 0 write |
| hp_cs_n | input | 1 | Chip select, active low |
| hp_ds1_n | input | 1 | Data strobe one, active low |
| hp_ds2_n | input | 1 | Data strobe two, active low |
| hp_as_n | input | 1 | Address strobe, unused in this mode |
| hp_data | inout | 16 | Bidirectional halfword data bus |
| hp_rdy_n | output | 1 | Ready, active low |
| hp_int | output | 1 | Interrupt to the host, active high |

## Verification
The bench builds the block with DEPTH=16 and LAT=4. With only 16 words, a run of post-increment accesses soon carries the address past the end of the store. That exercises the modulo index, and random addresses keep landing on words that have already been written, so read-back comparisons stay frequent. LAT=4 leaves a window long enough for a transfer issued straight after a word write to end while the port is still not ready, which is the case that must be ignored.

// File: rtl/hp16_pkg.sv
package hp16_pkg;

  typedef enum logic [1:0] {
    SEL_CTL = 2'b00,
    SEL_ADR = 2'b01,
    SEL_DAI = 2'b10,
    SEL_DFX = 2'b11
  } sel_e;

  typedef struct packed {
    sel_e        sel;
    logic        half;
    logic        rnw;
    logic [15:0] data;
  } xfer_t;

  // Does this halfword transfer address the upper 16 bits of a word?
  function automatic logic targets_high(logic half, logic hi_first);
    return half ^ hi_first;
  endfunction

  function automatic logic [15:0] pick_half(logic [31:0] w, logic hi);
    return hi ? w[31:16] : w[15:0];
  endfunction

  function automatic logic [31:0] put_half(logic [31:0] w, logic [15:0] h, logic hi);
    return hi ? {h, w[15:0]} : {w[31:16], h};
  endfunction

  function automatic logic [31:0] next_word_addr(logic [31:0] a);
    return a + 32'd4;
  endfunction

endpackage

// File: rtl/hp16_strobe.sv
module hp16_strobe
  import hp16_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs_n,
  input  logic        ds1_n,
  input  logic        ds2_n,
  input  logic [1:0]  sel,
  input  logic        half,
  input  logic        rnw,
  input  logic [15:0] din,
  output logic        stb_act,
  output logic        done,
  output xfer_t       cap
);
  logic stb_q;

  // qualified strobe: chip selected and exactly one data strobe low
  assign stb_act = !cs_n && (ds1_n ^ ds2_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q <= 1'b0;
      cap   <= '0;
    end else begin
      stb_q <= stb_act;
      if (stb_act) cap <= '{sel: sel_e'(sel), half: half, rnw: rnw, data: din};
    end
  end

  // release of the strobe commits the captured transfer
  assign done = stb_q && !stb_act;
endmodule

// File: rtl/hp16_ready.sv
module hp16_ready #(
  parameter int LAT = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(LAT + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (start)      cnt <= CW'(LAT);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/hp16_regs.sv
module hp16_regs
  import hp16_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        go,
  input  xfer_t       cap,
  input  logic        word_done,
  input  logic        loc_int_set,
  output logic [31:0] addr_q,
  output logic        hi_first,
  output logic        int_flag
);
  logic ctl_wr, adr_wr;

  assign ctl_wr = go && (cap.sel == SEL_CTL) && !cap.rnw;
  assign adr_wr = go && (cap.sel == SEL_ADR) && !cap.rnw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      hi_first <= 1'b0;
      int_flag <= 1'b0;
    end else begin
      if (loc_int_set)                 int_flag <= 1'b1;
      else if (ctl_wr && cap.data[1])  int_flag <= 1'b0;
      if (ctl_wr) hi_first <= cap.data[0];
      if (adr_wr)
        addr_q <= put_half(addr_q, cap.data, targets_high(cap.half, hi_first));
      else if (word_done && (cap.sel == SEL_DAI))
        addr_q <= next_word_addr(addr_q);
    end
  end
endmodule

// File: rtl/hp16_wordmem.sv
module hp16_wordmem
  import hp16_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  xfer_t         cap,
  input  logic          hi_first,
  input  logic [IW-1:0] idx,
  output logic [31:0]   mem_word,
  output logic [31:0]   rd_hold
);
  logic [31:0] mem [DEPTH];
  logic [31:0] wr_hold;
  logic        dat_go, hi;

  assign dat_go   = go && (cap.sel == SEL_DAI || cap.sel == SEL_DFX);
  assign hi       = targets_high(cap.half, hi_first);
  assign mem_word = mem[idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_hold <= '0;
      rd_hold <= '0;
    end else if (dat_go) begin
      if (!cap.rnw && !cap.half) wr_hold <= put_half(wr_hold, cap.data, hi);
      if (cap.rnw && !cap.half)  rd_hold <= mem_word;
    end
  end

  always_ff @(posedge clk) begin
    if (dat_go && !cap.rnw && cap.half) mem[idx] <= put_half(wr_hold, cap.data, hi);
  end
endmodule

// File: rtl/hport16_slave.sv
module hport16_slave
  import hp16_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int LAT   = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        loc_int_set,
  input  logic [1:0]  hp_sel,
  input  logic        hp_half,
  input  logic        hp_rnw,
  input  logic        hp_cs_n,
  input  logic        hp_ds1_n,
  input  logic        hp_ds2_n,
  input  logic        hp_as_n,
  inout  wire  [15:0] hp_data,
  output logic        hp_rdy_n,
  output logic        hp_int
);
  localparam int IW = $clog2(DEPTH);

  // named internal events, visible to the bound checker
  logic        stb_act, done, busy, go, word_done, wr_commit, bus_oe;
  logic        hi_first, int_flag, hi_now;
  logic [31:0] addr_q, mem_word, rd_hold;
  logic [15:0] rd_val;
  logic        as_unused;
  xfer_t       cap;

  assign as_unused = hp_as_n;

  hp16_strobe u_stb (
    .clk(clk), .rst_n(rst_n), .cs_n(hp_cs_n), .ds1_n(hp_ds1_n), .ds2_n(hp_ds2_n),
    .sel(hp_sel), .half(hp_half), .rnw(hp_rnw), .din(hp_data),
    .stb_act(stb_act), .done(done), .cap(cap)
  );

  assign go        = done && !busy;
  assign word_done = go && (cap.sel == SEL_DAI || cap.sel == SEL_DFX) && cap.half;
  assign wr_commit = word_done && !cap.rnw;

  hp16_ready #(.LAT(LAT)) u_rdy (
    .clk(clk), .rst_n(rst_n), .start(wr_commit), .busy(busy)
  );

  hp16_regs u_regs (
    .clk(clk), .rst_n(rst_n), .go(go), .cap(cap), .word_done(word_done),
    .loc_int_set(loc_int_set), .addr_q(addr_q), .hi_first(hi_first), .int_flag(int_flag)
  );

  hp16_wordmem #(.DEPTH(DEPTH)) u_mem (
    .clk(clk), .rst_n(rst_n), .go(go), .cap(cap), .hi_first(hi_first),
    .idx(addr_q[IW+1:2]), .mem_word(mem_word), .rd_hold(rd_hold)
  );

  // read mux follows the live pins so data is valid while the strobe is held
  assign hi_now = targets_high(hp_half, hi_first);
  always_comb begin
    case (sel_e'(hp_sel))
      SEL_CTL: rd_val = {14'b0, int_flag, hi_first};
      SEL_ADR: rd_val = pick_half(addr_q, hi_now);
      default: rd_val = hp_half ? pick_half(rd_hold, hi_now) : pick_half(mem_word, hi_now);
    endcase
  end

  assign bus_oe   = stb_act && hp_rnw;
  assign hp_data  = bus_oe ? rd_val : 16'bz;
  assign hp_rdy_n = busy;
  assign hp_int   = int_flag;
endmodule

// File: rtl/hport16_checker.sv
module hport16_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        hp_cs_n,
  input logic        hp_ds1_n,
  input logic        hp_ds2_n,
  input logic        hp_rnw,
  input logic        hp_rdy_n,
  input logic        hp_int,
  input logic        loc_int_set,
  input logic        bus_oe,
  input logic        done,
  input logic        busy,
  input logic        go,
  input logic [1:0]  cap_sel,
  input logic        cap_half,
  input logic        cap_rnw,
  input logic [31:0] addr_q
);
  // R1: no drive unless the host is selecting and reading
  assert_bus_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (hp_cs_n || !hp_rnw) |-> !bus_oe);

  // R2: both data strobes low never qualifies a transfer
  assert_no_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!hp_ds1_n && !hp_ds2_n) |=> !done);

  assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (go && cap_sel == 2'b10 && cap_half) |=> (addr_q == $past(addr_q) + 32'd4));

  assert_addr_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (go && cap_sel == 2'b11) |=> $stable(addr_q));

  assert_not_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (go && cap_sel[1] && cap_half && !cap_rnw) |=> hp_rdy_n);

  assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && busy) |=> $stable(addr_q));

  assert_irq_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    loc_int_set |=> hp_int);
endmodule

bind hport16_slave hport16_checker u_chk (
  .clk(clk), .rst_n(rst_n), .hp_cs_n(hp_cs_n), .hp_ds1_n(hp_ds1_n), .hp_ds2_n(hp_ds2_n),
  .hp_rnw(hp_rnw), .hp_rdy_n(hp_rdy_n), .hp_int(hp_int), .loc_int_set(loc_int_set),
  .bus_oe(bus_oe), .done(done), .busy(busy), .go(go), .cap_sel(cap.sel),
  .cap_half(cap.half), .cap_rnw(cap.rnw), .addr_q(addr_q)
);

// File: tb/hport16_slave_tb.sv
`timescale 1ns/1ps
module hport16_slave_tb;
  localparam int DEPTH = 16;
  localparam int LAT   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        loc_int_set = 0, hp_half = 0, hp_rnw = 1;
  logic        hp_cs_n = 1, hp_ds1_n = 1, hp_ds2_n = 1, hp_as_n = 1;
  logic [1:0]  hp_sel = 0;
  logic        hp_rdy_n, hp_int;
  logic [15:0] tb_drv = 0;
  logic        tb_oe = 0;
  wire  [15:0] hp_data;
  assign hp_data = tb_oe ? tb_drv : 16'bz;

  hport16_slave #(.DEPTH(DEPTH), .LAT(LAT)) u_dut (
    .clk(clk), .rst_n(rst_n), .loc_int_set(loc_int_set), .hp_sel(hp_sel),
    .hp_half(hp_half), .hp_rnw(hp_rnw), .hp_cs_n(hp_cs_n), .hp_ds1_n(hp_ds1_n),
    .hp_ds2_n(hp_ds2_n), .hp_as_n(hp_as_n), .hp_data(hp_data),
    .hp_rdy_n(hp_rdy_n), .hp_int(hp_int)
  );

  int checks = 0, errors = 0;
  bit as_low_all = 0;

  // bench-side model
  logic [31:0] m_addr = 0;
  bit          m_hf = 0;
  logic [31:0] m_mem [DEPTH];
  bit          m_vld [DEPTH];

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit upper_of(bit h, bit hf);
    return (h == 1'b1) != (hf == 1'b1);
  endfunction

  function automatic int widx(logic [31:0] a);
    return int'((a >> 2) % DEPTH);
  endfunction

  function automatic logic [15:0] part(logic [31:0] w, bit up);
    if (up) return w[31:16];
    return w[15:0];
  endfunction

  // one halfword transfer; starts and ends on a falling clock edge
  task automatic xfer(input logic [1:0] s, input bit h, input bit r, input logic [15:0] wd,
                      input bit wait_rdy, output logic [15:0] rd);
    if (wait_rdy) while (hp_rdy_n) @(negedge clk);
    hp_sel = s; hp_half = h; hp_rnw = r;
    tb_drv = wd; tb_oe = !r;
    hp_as_n = as_low_all ? 1'b0 : 1'($urandom_range(0, 1));
    hp_cs_n = 0;
    if ($urandom_range(0, 1) == 1) hp_ds1_n = 0; else hp_ds2_n = 0;
    @(negedge clk);
    rd = hp_data;
    hp_cs_n = 1; hp_ds1_n = 1; hp_ds2_n = 1; tb_oe = 0; hp_rnw = 1;
    @(negedge clk);
  endtask

  task automatic set_addr(logic [31:0] a);
    logic [15:0] d;
    for (int h = 0; h < 2; h++) xfer(2'b01, h[0], 0, part(a, upper_of(h[0], m_hf)), 1, d);
    m_addr = a;
  endtask

  task automatic get_addr(output logic [31:0] a);
    logic [15:0] d;
    a = 0;
    for (int h = 0; h < 2; h++) begin
      xfer(2'b01, h[0], 1, 16'h0, 1, d);
      if (upper_of(h[0], m_hf)) a[31:16] = d; else a[15:0] = d;
    end
  endtask

  task automatic wr_word(logic [1:0] mode, logic [31:0] w);
    logic [15:0] d;
    for (int h = 0; h < 2; h++) xfer(mode, h[0], 0, part(w, upper_of(h[0], m_hf)), 1, d);
    m_mem[widx(m_addr)] = w;
    m_vld[widx(m_addr)] = 1;
    if (mode == 2'b10) m_addr = m_addr + 4;
  endtask

  task automatic rd_word(logic [1:0] mode, output logic [31:0] w,
                         output logic [31:0] exp, output bit vld);
    logic [15:0] d;
    exp = m_mem[widx(m_addr)];
    vld = m_vld[widx(m_addr)];
    w = 0;
    for (int h = 0; h < 2; h++) begin
      xfer(mode, h[0], 1, 16'h0, 1, d);
      if (upper_of(h[0], m_hf)) w[31:16] = d; else w[15:0] = d;
    end
    if (mode == 2'b10) m_addr = m_addr + 4;
  endtask

  task automatic ctl_write(logic [15:0] v);
    logic [15:0] d;
    xfer(2'b00, 0, 0, v, 1, d);
    m_hf = v[0];
  endtask

  task automatic ctl_read(output logic [15:0] v);
    xfer(2'b00, 1'($urandom_range(0, 1)), 1, 16'h0, 1, v);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] a, w, e;
    logic [15:0] d;
    bit v;
    int n;
    void'($urandom(32'd1234));
    for (int i = 0; i < DEPTH; i++) m_vld[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // reset state
    chk("R9 reset ready low", 32'(hp_rdy_n), 0);
    chk("R10 reset interrupt low", 32'(hp_int), 0);
    ctl_read(d);
    chk("R3 control reset value", 32'(d), 0);

    // R4: address halves in both orderings
    set_addr(32'h0000_0010);
    get_addr(a);
    chk("R4 address low-first", a, 32'h0000_0010);
    ctl_write(16'h0001);
    ctl_read(d);
    chk("R3 high-first bit", 32'(d), 32'h1);
    set_addr(32'hA5C3_0028);
    get_addr(a);
    chk("R4 address high-first", a, 32'hA5C3_0028);
    xfer(2'b01, 0, 0, 16'hBEEF, 1, d);   // first halfword lands in bits 31:16
    get_addr(a);
    chk("R4 first halfword is upper", a, 32'hBEEF_0028);
    ctl_write(16'h0000);

    // R1: bus left alone when the strobe is not a qualified read
    set_addr(32'h0001_0004);
    hp_sel = 2'b01; hp_rnw = 1; hp_cs_n = 1; hp_ds1_n = 0; tb_drv = 16'h0000; tb_oe = 1;
    @(negedge clk);
    chk("R1 no drive with chip select high", 32'(hp_data), 0);
    hp_cs_n = 0; hp_ds2_n = 0;
    @(negedge clk);
    chk("R1 no drive with both strobes low", 32'(hp_data), 0);
    hp_cs_n = 1; hp_ds1_n = 1; hp_ds2_n = 1; tb_oe = 0;
    @(negedge clk);

    // R6/R7/R8/R9: fixed-address write, latency, read back
    set_addr(32'h0);
    wr_word(2'b11, 32'hCAFE_F00D);
    chk("R9 not ready after word write", 32'(hp_rdy_n), 1);
    n = 0;
    while (hp_rdy_n) begin n++; @(negedge clk); end
    chk("R9 not-ready length", n, LAT);
    get_addr(a);
    chk("R6 fixed mode keeps address", a, 32'h0);
    rd_word(2'b11, w, e, v);
    chk("R7 R8 fixed read back", w, 32'hCAFE_F00D);

    // R5: post-increment write and read
    wr_word(2'b10, 32'h0102_0304);
    wr_word(2'b10, 32'h0506_0708);
    get_addr(a);
    chk("R5 address after two words", a, 32'h8);
    set_addr(32'h0);
    rd_word(2'b10, w, e, v);
    chk("R5 first incremented read", w, 32'h0102_0304);
    rd_word(2'b10, w, e, v);
    chk("R5 second incremented read", w, 32'h0506_0708);
    get_addr(a);
    chk("R5 address after two reads", a, 32'h8);

    // R7: placement stays coherent across a change of ordering
    ctl_write(16'h0001);
    set_addr(32'h30);
    wr_word(2'b11, 32'h1111_2222);
    ctl_write(16'h0000);
    xfer(2'b11, 0, 1, 16'h0, 1, d);
    chk("R7 first half with low-first", 32'(d), 32'h2222);
    xfer(2'b11, 1, 1, 16'h0, 1, d);
    chk("R7 second half from latch", 32'(d), 32'h1111);

    // R2: both data strobes low does not transfer
    set_addr(32'h40);
    hp_sel = 2'b01; hp_half = 0; hp_rnw = 0; tb_drv = 16'h7777; tb_oe = 1;
    hp_cs_n = 0; hp_ds1_n = 0; hp_ds2_n = 0;
    @(negedge clk);
    hp_cs_n = 1; hp_ds1_n = 1; hp_ds2_n = 1; tb_oe = 0; hp_rnw = 1;
    @(negedge clk);
    get_addr(a);
    chk("R2 double strobe ignored", a, 32'h40);

    // R9: transfer ending while not ready is ignored
    wr_word(2'b11, 32'h5555_AAAA);
    xfer(2'b01, 0, 0, 16'h00FC, 0, d);
    get_addr(a);
    chk("R9 busy transfer ignored", a, 32'h40);

    // R11: address strobe held low throughout
    as_low_all = 1;
    set_addr(32'h24);
    get_addr(a);
    chk("R11 address strobe ignored", a, 32'h24);
    as_low_all = 0;

    // R10/R3: interrupt set and clear
    loc_int_set = 1; @(negedge clk); loc_int_set = 0;
    chk("R10 interrupt raised", 32'(hp_int), 1);
    ctl_read(d);
    chk("R3 interrupt bit reads 1", 32'(d[1]), 1);
    ctl_write(16'h0000);
    chk("R3 writing 0 keeps interrupt", 32'(hp_int), 1);
    ctl_write(16'h0002);
    chk("R3 writing 1 clears interrupt", 32'(hp_int), 0);

    // random mix
    for (int i = 0; i < 80; i++) begin
      case ($urandom_range(0, 4))
        0: set_addr(32'($urandom_range(0, 4 * DEPTH - 1)) & 32'hFFFF_FFFC);
        1, 2: wr_word($urandom_range(0, 1) ? 2'b10 : 2'b11, $urandom);
        3: begin
          rd_word($urandom_range(0, 1) ? 2'b10 : 2'b11, w, e, v);
          if (v) chk("R7 random read", w, e);
        end
        default: ctl_write({15'b0, 1'($urandom_range(0, 1))});
      endcase
    end
    get_addr(a);
    chk("R5 R6 address after random mix", a, m_addr);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule